// File: doc/BRIEF.md
# Keyed Write-Lock Guard for a Receive Control Bank

This block guards a small bank of receive-side control registers behind a single lock bit. Software reaches the bank through a plain synchronous register bus: one write port (enable, address, data) and one read port (address in, registered data out). The lock register lives at the address just above the last control register. Its upper byte is a key field that must carry 0xA5 in the same write for the write to count. The key is never stored.

Once software sets the lock bit with a correctly keyed write, every control register marked lockable ignores further writes, and so does the lock register itself. Only the synchronous system reset clears the lock. Registers marked not lockable stay writable. Reads are unaffected by the lock. Dropped writes raise no error. The current value of every control register is driven out in parallel on `ctrl_q` for the datapath that the bank configures.

Top module: `rxg_lock_guard`

## Requirements
- R1: While `sys_rst` is high at a rising edge, `locked`, every control register and `rd_data` become zero after that edge.
- R2: Reading the lock address (address NUM_REGS) returns bit 0 equal to `locked` and zero in bits DATA_W-1:1, including the key byte.
- R3: A write to the lock address changes `locked` only when wr_data[15:8] equals 0xA5. With any other key byte the whole write is ignored.
- R4: While unlocked, a write to address i (0 to NUM_REGS-1) stores `wr_data` in register i, visible on ctrl_q[i*DATA_W +: DATA_W] after that edge.
- R5: While locked, a write to a register whose bit in LOCK_MASK is 1 leaves it unchanged.
- R6: A register whose bit in LOCK_MASK is 0 accepts writes whether or not the block is locked.
- R7: Once `locked` is 1, no write clears it, even a keyed write with bit 0 at 0. Only `sys_rst` returns it to 0.
- R8: A keyed write with bit 0 at 0 while unlocked leaves `locked` at 0 and changes no control register.
- R9: `rd_data` shows, one cycle after `rd_addr` is presented, the register at that address, whether locked or not. Addresses above NUM_REGS read zero.
- R10: The lock acts from the edge that accepts the locking write. A write to a lockable register in the very next cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sys_rst | input | 1 | Synchronous active-high system reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | DATA_W | Write data; top byte is the key for the lock address |
| rd_addr | input | ADDR_W | Read word address |
| rd_data | output | DATA_W | Registered read data |
| locked | output | 1 | Current lock state |
| ctrl_q | output | NUM_REGS*DATA_W | All control register values, register i in slice i |

## Verification
The properties assume that `wr_addr` and `wr_data` carry known values whenever `wr_en` is high, and that `sys_rst` changes only away from the rising edge. They also assume that a single write port means only one register can be addressed per cycle. The bench drives every input on the falling edge with defined values and holds reset for several cycles. It issues at most one write per cycle, so it stays within these assumptions. It sweeps every key byte against the lock address, every register under both lock states and every read address, including the unmapped ones.

// File: rtl/rxg_pkg.sv
package rxg_pkg;
  localparam int unsigned KEY_W   = 8;
  localparam logic [KEY_W-1:0] UNLOCK_KEY = 8'hA5;

  function automatic logic key_ok(input logic [KEY_W-1:0] k);
    return k == UNLOCK_KEY;
  endfunction
endpackage

// File: rtl/rxg_key_lock.sv
module rxg_key_lock
  import rxg_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit,
  input  logic [DATA_W-1:0] wdata,
  output logic              lock_q
);
  localparam int unsigned KEY_LSB = DATA_W - KEY_W;

  logic accept;

  // Sticky: once set, the register refuses every write until reset.
  assign accept = hit && !lock_q && key_ok(wdata[DATA_W-1:KEY_LSB]);

  always_ff @(posedge clk) begin
    if (rst)         lock_q <= 1'b0;
    else if (accept) lock_q <= wdata[0];
  end
endmodule

// File: rtl/rxg_ctrl_reg.sv
module rxg_ctrl_reg #(
  parameter int unsigned DATA_W   = 16,
  parameter bit          LOCKABLE = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit,
  input  logic              locked,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  logic take;

  generate
    if (LOCKABLE) begin : g_guarded
      assign take = hit && !locked;
    end else begin : g_open
      logic unused_lock;
      assign unused_lock = locked;
      assign take = hit;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (take) q <= wdata;
  end
endmodule

// File: rtl/rxg_read_mux.sv
module rxg_read_mux #(
  parameter int unsigned NUM_REGS = 4,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned ADDR_W   = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [NUM_REGS*DATA_W-1:0] regs,
  input  logic                       locked,
  output logic [DATA_W-1:0]          rdata
);
  localparam logic [ADDR_W-1:0] LOCK_ADDR = ADDR_W'(NUM_REGS);

  logic [DATA_W-1:0] sel;

  always_comb begin
    sel = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (addr == ADDR_W'(i)) sel = regs[i*DATA_W +: DATA_W];
    end
    if (addr == LOCK_ADDR) sel = {{(DATA_W-1){1'b0}}, locked};
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= sel;
  end
endmodule

// File: rtl/rxg_lock_guard.sv
module rxg_lock_guard #(
  parameter int unsigned NUM_REGS  = 4,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned ADDR_W    = 3,
  parameter logic [NUM_REGS-1:0] LOCK_MASK = 4'b0101
) (
  input  logic                       clk,
  input  logic                       sys_rst,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic [ADDR_W-1:0]          rd_addr,
  output logic [DATA_W-1:0]          rd_data,
  output logic                       locked,
  output logic [NUM_REGS*DATA_W-1:0] ctrl_q
);
  localparam logic [ADDR_W-1:0] LOCK_ADDR = ADDR_W'(NUM_REGS);

  logic lock_hit;
  assign lock_hit = wr_en && (wr_addr == LOCK_ADDR);

  rxg_key_lock #(.DATA_W(DATA_W)) u_lock (
    .clk    (clk),
    .rst    (sys_rst),
    .hit    (lock_hit),
    .wdata  (wr_data),
    .lock_q (locked)
  );

  generate
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      logic hit;
      assign hit = wr_en && (wr_addr == ADDR_W'(i));
      rxg_ctrl_reg #(.DATA_W(DATA_W), .LOCKABLE(LOCK_MASK[i])) u_reg (
        .clk    (clk),
        .rst    (sys_rst),
        .hit    (hit),
        .locked (locked),
        .wdata  (wr_data),
        .q      (ctrl_q[i*DATA_W +: DATA_W])
      );
    end
  endgenerate

  rxg_read_mux #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
    .clk    (clk),
    .rst    (sys_rst),
    .addr   (rd_addr),
    .regs   (ctrl_q),
    .locked (locked),
    .rdata  (rd_data)
  );
endmodule

// File: rtl/rxg_lock_guard_chk.sv
module rxg_lock_guard_chk #(
  parameter int unsigned NUM_REGS  = 4,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned ADDR_W    = 3,
  parameter logic [NUM_REGS-1:0] LOCK_MASK = 4'b0101
) (
  input logic                       clk,
  input logic                       sys_rst,
  input logic                       wr_en,
  input logic [ADDR_W-1:0]          wr_addr,
  input logic [DATA_W-1:0]          wr_data,
  input logic [ADDR_W-1:0]          rd_addr,
  input logic [DATA_W-1:0]          rd_data,
  input logic                       locked,
  input logic [NUM_REGS*DATA_W-1:0] ctrl_q
);
  localparam logic [ADDR_W-1:0] LOCK_ADDR = ADDR_W'(NUM_REGS);

  // R7: lock never drops without reset
  p_sticky_r7: assert property (@(posedge clk) disable iff (sys_rst)
    (locked && !sys_rst) |=> locked);

  // R3: lock only rises after a keyed write with bit 0 set
  p_keyed_rise_r3: assert property (@(posedge clk) disable iff (sys_rst)
    $rose(locked) |-> $past(wr_en && wr_addr == LOCK_ADDR &&
                            wr_data[DATA_W-1 -: 8] == 8'hA5 && wr_data[0]));

  // R2: lock read view has zero key and reserved bits
  p_lock_view_r2: assert property (@(posedge clk) disable iff (sys_rst)
    (rd_addr == LOCK_ADDR && !sys_rst) |=> (rd_data[DATA_W-1:1] == '0));

  // R9: unmapped addresses read zero
  p_unmapped_r9: assert property (@(posedge clk) disable iff (sys_rst)
    (rd_addr > LOCK_ADDR && !sys_rst) |=> (rd_data == '0));

  generate
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_chk
      if (LOCK_MASK[i]) begin : g_lk
        // R5: lockable register frozen while locked
        p_frozen_r5: assert property (@(posedge clk) disable iff (sys_rst)
          (locked && !sys_rst) |=> $stable(ctrl_q[i*DATA_W +: DATA_W]));
      end else begin : g_op
        // R6: open register takes writes even while locked
        p_open_r6: assert property (@(posedge clk) disable iff (sys_rst)
          (wr_en && wr_addr == ADDR_W'(i) && !sys_rst) |=>
            (ctrl_q[i*DATA_W +: DATA_W] == $past(wr_data)));
      end
      // R4: unlocked write lands
      p_write_r4: assert property (@(posedge clk) disable iff (sys_rst)
        (wr_en && wr_addr == ADDR_W'(i) && !locked && !sys_rst) |=>
          (ctrl_q[i*DATA_W +: DATA_W] == $past(wr_data)));
    end
  endgenerate
endmodule

bind rxg_lock_guard rxg_lock_guard_chk #(
  .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LOCK_MASK(LOCK_MASK)
) u_chk (
  .clk(clk), .sys_rst(sys_rst), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
  .locked(locked), .ctrl_q(ctrl_q)
);

// File: tb/rxg_lock_guard_bench.sv
`timescale 1ns/1ps
module rxg_lock_guard_bench;
  localparam int NR = 4;
  localparam int DW = 16;
  localparam int AW = 3;
  localparam logic [NR-1:0] MASK = 4'b0101;

  logic clk = 1'b0;
  logic sys_rst = 1'b1;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic locked;
  logic [NR*DW-1:0] ctrl_q;

  int nvec = 0;
  int nfail = 0;
  logic [DW-1:0] expq [NR];
  logic exp_lock;

  always #2 clk = ~clk;

  rxg_lock_guard #(.NUM_REGS(NR), .DATA_W(DW), .ADDR_W(AW), .LOCK_MASK(MASK)) u_rxg_lock_guard (
    .clk(clk), .sys_rst(sys_rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .locked(locked), .ctrl_q(ctrl_q)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input int a, input logic [DW-1:0] d);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [DW-1:0] d);
    rd_addr = AW'(a);
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic do_reset();
    sys_rst = 1'b1;
    repeat (3) @(negedge clk);
    sys_rst = 1'b0;
    exp_lock = 1'b0;
    for (int i = 0; i < NR; i++) expq[i] = '0;
  endtask

  task automatic check_all(input string req);
    logic [DW-1:0] v;
    chk(req, {15'd0, locked}, {15'd0, exp_lock});
    for (int i = 0; i < NR; i++) chk(req, ctrl_q[i*DW +: DW], expq[i]);
    for (int a = 0; a < 8; a++) begin
      rd(a, v);
      if (a < NR)       chk("R9", v, expq[a]);
      else if (a == NR) chk("R2", v, {15'd0, exp_lock});
      else              chk("R9", v, '0);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int i, input int k);
    return DW'(k * 16'h1357 + i * 16'h0F0F + 16'h0011);
  endfunction

  initial begin
    logic [DW-1:0] v;
    @(negedge clk);
    do_reset();
    check_all("R1");

    // R3: every wrong key with bit 0 set is ignored
    for (int k = 0; k < 256; k++) begin
      if (k != 8'hA5) begin
        wr(NR, {8'(k), 8'hFF});
        chk("R3", {15'd0, locked}, 16'd0);
      end
    end

    // R8: keyed write of 0 while unlocked changes nothing
    for (int i = 0; i < NR; i++) begin
      wr(i, pat(i, 1));
      expq[i] = pat(i, 1);
    end
    wr(NR, 16'hA500);
    check_all("R8");

    // R4: unlocked writes land, several patterns
    for (int k = 2; k < 6; k++) begin
      for (int i = 0; i < NR; i++) begin
        wr(i, pat(i, k));
        expq[i] = pat(i, k);
        chk("R4", ctrl_q[i*DW +: DW], expq[i]);
      end
    end

    // R3 + R10: keyed lock, then a write to lockable reg 0 next cycle
    wr(NR, 16'hA501);
    exp_lock = 1'b1;
    wr(0, 16'hDEAD);
    chk("R10", ctrl_q[0 +: DW], expq[0]);
    chk("R3", {15'd0, locked}, 16'd1);

    // R5 / R6: lockable frozen, open ones still writable
    for (int k = 6; k < 10; k++) begin
      for (int i = 0; i < NR; i++) begin
        wr(i, pat(i, k));
        if (!MASK[i]) begin
          expq[i] = pat(i, k);
          chk("R6", ctrl_q[i*DW +: DW], expq[i]);
        end else begin
          chk("R5", ctrl_q[i*DW +: DW], expq[i]);
        end
      end
    end
    check_all("R9");

    // R7: nothing clears the lock
    for (int k = 0; k < 256; k++) begin
      wr(NR, {8'(k), 8'h00});
      chk("R7", {15'd0, locked}, 16'd1);
    end
    rd(NR, v);
    chk("R2", v, 16'h0001);

    // R7 / R1: reset releases it
    do_reset();
    check_all("R7");
    wr(0, 16'h1234);
    expq[0] = 16'h1234;
    chk("R4", ctrl_q[0 +: DW], 16'h1234);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule